// File: doc/BRIEF.md
# Converter Serial Register Port

This block is the device-side serial control port of a sensor converter. An external host talks to it over four wires: an active-low select, a serial clock that idles high, a data input, and one output pin that carries register data while a read is shifting and otherwise shows a ready flag, where low means a new result is waiting. The serial wires are sampled by the block's system clock, so the serial clock must run well below it. An SCLK half period of eight system clocks or more is assumed.

Every access opens with one command byte. Bit 7 must be 0 or the whole byte is dropped. Bit 6 picks a read (1) or a write (0). Bits 5:3 name the target register. Bit 2 matters only for the byte that turns on continuous read. After the command byte, 8 or 24 bits move MSB first. The host drives data-in and the block latches it on the rising serial clock edge. The block changes its output on the falling edge.

The converter core outside this block delivers each finished 24-bit result with a one-cycle strobe. The block holds that result in the data register and pulls the ready flag low. The mode, configuration and offset words are driven out to the core. A run of forty 1 bits on data-in restores every register to its reset value.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, reads return 0x80 for status (address 000, 8 bits), 0x080060 for mode (001), 0x000117 for configuration (010), 0x000000 for data (011) and 0x800000 for offset (110). The output pin is high, meaning not ready.
- R2: A command byte with bit 7 set is ignored in full, and the next eight bits are taken as a new command byte.
- R3: Data moves MSB first. Data-in is latched on the rising serial clock edge and the output changes on the falling edge. A status access is 8 bits long and every other access is 24 bits.
- R4: A write command ({00, address, 000}) followed by 24 bits stores them in mode, configuration or offset. The stored word appears on the matching output port. A write to the data register leaves it unchanged.
- R5: A conversion strobe loads the result into the data register and sets the ready flag. Status bit 7 then reads 0 and the output pin is low between transfers.
- R6: Completing a 24-bit read of the data register clears the ready flag, so the pin goes high. A status read does not change the flag.
- R7: Whenever no read is shifting, the output pin shows the ready flag.
- R8: Raising select in the middle of a transfer abandons it, and the next byte after select falls again is a command byte.
- R9: Command byte 0x5C turns on continuous read. While it is on and select is low, each new result is shifted out as 24 bits without a command byte.
- R10: While continuous read is on, the byte 0x58 turns it off. Later commands then behave normally.
- R11: Forty consecutive 1 bits on data-in reset all registers, the ready flag and continuous read. Thirty-nine 1 bits followed by a 0 do not.
- R12: A strobe that arrives while the data register is being read does not disturb the read. The new result is loaded, and the flag set, when the transfer ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial wires |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host, idles high |
| sdi | input | 1 | Serial data from the host |
| sdo_rdy | output | 1 | Read data while shifting, otherwise the ready flag (low = result waiting) |
| conv_strobe | input | 1 | One-cycle pulse marking a finished conversion |
| conv_result | input | 24 | Conversion result valid with the strobe |
| mode_word | output | 24 | Current mode register |
| cfg_word | output | 24 | Current configuration register |
| ofs_word | output | 24 | Current offset register |

## Verification
The two functions that can fall in the same cycle are the end of a data-register read and the arrival of a conversion strobe. The bench provokes this twice. In the first case it pulses the strobe partway through a data read. In the second it times the strobe onto the rising edge that finishes the read.

In both cases the read must still return the old word. The pin must then fall to ready, and a fresh read must return the new result. This shows that the deferred update took priority over the flag being cleared by the completed read.

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int W       = 24,
  parameter int ONES_N  = 40,
  parameter logic [W-1:0] MODE_RST = 24'h080060,
  parameter logic [W-1:0] CFG_RST  = 24'h000117,
  parameter logic [W-1:0] OFS_RST  = 24'h800000,
  parameter logic [7:0] CREAD_ON  = 8'h5C,
  parameter logic [7:0] CREAD_OFF = 8'h58
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         sclk,
  input  logic         sdi,
  output logic         sdo_rdy,
  input  logic         conv_strobe,
  input  logic [W-1:0] conv_result,
  output logic [W-1:0] mode_word,
  output logic [W-1:0] cfg_word,
  output logic [W-1:0] ofs_word
);
  localparam int CNTW = $clog2(W);
  localparam int ONW  = $clog2(ONES_N + 1);
  localparam logic [CNTW-1:0] LAST_W = CNTW'(W - 1);
  localparam logic [CNTW-1:0] LAST_B = CNTW'(7);

  logic [1:0] cs_sr, sdi_sr;
  logic [2:0] sck_sr;
  logic cs_act, rise, fall, bit_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_sr <= '1; sdi_sr <= '0; sck_sr <= '1;
    end else begin
      cs_sr  <= {cs_sr[0], cs_n};
      sdi_sr <= {sdi_sr[0], sdi};
      sck_sr <= {sck_sr[1:0], sclk};
    end
  end

  assign cs_act = !cs_sr[1];
  assign bit_in = sdi_sr[1];
  assign rise   = cs_act & sck_sr[1] & !sck_sr[2];
  assign fall   = cs_act & !sck_sr[1] & sck_sr[2];

  logic            xfer, rd, out_en, cread, rdy_q, pend;
  logic [2:0]      addr;
  logic [CNTW-1:0] cnt;
  logic [ONW-1:0]  ones;
  logic [W-1:0]    sh, data_q, pend_val;
  logic [7:0]      cmd_byte;
  logic [W-1:0]    sel_val;
  logic [CNTW-1:0] len_last;
  logic            ones_hit, data_busy, data_end, release_rd, auto_go;

  assign cmd_byte   = {sh[6:0], bit_in};
  assign len_last   = (addr == 3'd0) ? LAST_B : LAST_W;
  assign ones_hit   = rise & bit_in & (ones == ONW'(ONES_N - 1));
  assign data_busy  = xfer & rd & (addr == 3'd3);
  assign data_end   = data_busy & rise & (cnt == LAST_W);
  assign release_rd = data_end | (data_busy & !cs_act);
  assign auto_go    = cread & !xfer & cs_act & !rise & (cnt == '0) & !rdy_q;

  always_comb begin
    case (cmd_byte[5:3])
      3'd0:    sel_val = {rdy_q, 7'd0, 16'd0};
      3'd1:    sel_val = mode_word;
      3'd2:    sel_val = cfg_word;
      3'd3:    sel_val = data_q;
      3'd6:    sel_val = ofs_word;
      default: sel_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ones_hit) begin
      xfer <= 1'b0; rd <= 1'b0; out_en <= 1'b0; cread <= 1'b0;
      addr <= '0; cnt <= '0; ones <= '0; sh <= '0;
      mode_word <= MODE_RST; cfg_word <= CFG_RST; ofs_word <= OFS_RST;
      data_q <= '0; rdy_q <= 1'b1; pend <= 1'b0; pend_val <= '0;
    end else begin
      if (rise) ones <= bit_in ? ones + 1'b1 : '0;

      if (!cs_act) begin
        xfer <= 1'b0; cnt <= '0; out_en <= 1'b0;
      end else if (!xfer) begin
        if (auto_go) begin
          xfer <= 1'b1; rd <= 1'b1; addr <= 3'd3; sh <= data_q;
          cnt <= '0; out_en <= 1'b0;
        end else if (rise) begin
          sh  <= {sh[W-2:0], bit_in};
          cnt <= cnt + 1'b1;
          if (cnt == LAST_B) begin
            cnt <= '0;
            if (!cmd_byte[7]) begin
              if (cread) begin
                if (cmd_byte == CREAD_OFF) cread <= 1'b0;
              end else if (cmd_byte == CREAD_ON) begin
                cread <= 1'b1;
              end else if (cmd_byte[6] || cmd_byte[5:3] != 3'd0) begin
                xfer <= 1'b1; rd <= cmd_byte[6]; addr <= cmd_byte[5:3];
                sh <= sel_val; out_en <= 1'b0;
              end
            end
          end
        end
      end else begin
        if (fall && rd) begin
          if (!out_en) out_en <= 1'b1;
          else sh <= {sh[W-2:0], 1'b0};
        end
        if (rise) begin
          if (!rd) sh <= {sh[W-2:0], bit_in};
          cnt <= cnt + 1'b1;
          if (cnt == len_last) begin
            xfer <= 1'b0; cnt <= '0; out_en <= 1'b0;
            if (!rd) begin
              case (addr)
                3'd1: mode_word <= {sh[W-2:0], bit_in};
                3'd2: cfg_word  <= {sh[W-2:0], bit_in};
                3'd6: ofs_word  <= {sh[W-2:0], bit_in};
                default: ;
              endcase
            end
          end
        end
      end

      if (release_rd) begin
        if (data_end) rdy_q <= 1'b1;
        if (conv_strobe) begin
          data_q <= conv_result; rdy_q <= 1'b0; pend <= 1'b0;
        end else if (pend) begin
          data_q <= pend_val; rdy_q <= 1'b0; pend <= 1'b0;
        end
      end else if (conv_strobe) begin
        if (data_busy) begin
          pend <= 1'b1; pend_val <= conv_result;
        end else begin
          data_q <= conv_result; rdy_q <= 1'b0;
        end
      end
    end
  end

  assign sdo_rdy = (xfer && rd && out_en) ? sh[W-1] : rdy_q;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST_W); // R3
  AST_STROBE_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    conv_strobe && !data_busy && !ones_hit |=> !rdy_q); // R5
  AST_READ_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    data_end && !conv_strobe && !pend && !ones_hit |=> rdy_q); // R6
  AST_DESELECT_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !xfer && cnt == '0); // R8
  AST_SERIAL_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    ones_hit |=> mode_word == MODE_RST && ofs_word == OFS_RST && rdy_q && !cread); // R11
  AST_DEFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    data_busy && cs_act && !data_end && !ones_hit |=> $stable(data_q)); // R12
endmodule

// File: tb/tb_adc_serial_port.sv
module tb_adc_serial_port;
  localparam int HALF = 8;
  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 1, sdi = 0, conv_strobe = 0;
  logic [23:0] conv_result = '0;
  logic sdo_rdy;
  logic [23:0] mode_word, cfg_word, ofs_word;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  adc_serial_port dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo_rdy(sdo_rdy), .conv_strobe(conv_strobe), .conv_result(conv_result),
    .mode_word(mode_word), .cfg_word(cfg_word), .ofs_word(ofs_word));

  task automatic chk(input string req, input logic [23:0] got, input logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitx(input logic b, output logic r);
    @(negedge clk); sclk = 0; sdi = b;
    wclk(HALF); r = sdo_rdy; sclk = 1;
    wclk(HALF);
  endtask

  task automatic send_byte(input logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) bitx(v[i], r);
  endtask

  task automatic shift_n(input int n, input logic [23:0] w, output logic [23:0] r);
    logic b;
    r = '0;
    for (int i = n - 1; i >= 0; i--) begin
      bitx(w[i], b);
      r = {r[22:0], b};
    end
  endtask

  task automatic strobe(input logic [23:0] v);
    @(negedge clk); conv_strobe = 1; conv_result = v;
    @(negedge clk); conv_strobe = 0;
    wclk(2);
  endtask

  task automatic txn(input logic [7:0] cmd, input int n, input logic [23:0] w, output logic [23:0] r);
    cs_n = 0; wclk(4);
    send_byte(cmd);
    r = '0;
    if (n > 0) shift_n(n, w, r);
    wclk(4); cs_n = 1; wclk(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [23:0] r, v, old;
    logic b;
    wclk(5); rst_n = 1; wclk(5);

    chk("R1 R7 idle pin", {23'd0, sdo_rdy}, 24'd1);
    txn(8'h40, 8, 0, r);  chk("R1 status", r, 24'h80);
    txn(8'h48, 24, 0, r); chk("R1 mode", r, 24'h080060);
    txn(8'h50, 24, 0, r); chk("R1 config", r, 24'h000117);
    txn(8'h58, 24, 0, r); chk("R1 data", r, 24'h0);
    txn(8'h70, 24, 0, r); chk("R1 offset", r, 24'h800000);

    for (int i = 0; i < 6; i++) begin
      v = 24'h0F1E2D * (i + 1) ^ (24'(i) << 20);
      txn(8'h08, 24, v, r);
      txn(8'h10, 24, ~v, r);
      txn(8'h30, 24, v ^ 24'h5A5A5A, r);
      txn(8'h48, 24, 0, r); chk("R3 R4 mode", r, v);
      txn(8'h50, 24, 0, r); chk("R3 R4 config", r, ~v);
      txn(8'h70, 24, 0, r); chk("R3 R4 offset", r, v ^ 24'h5A5A5A);
      chk("R4 mode port", mode_word, v);
      chk("R4 config port", cfg_word, ~v);
      chk("R4 offset port", ofs_word, v ^ 24'h5A5A5A);
    end

    cs_n = 0; wclk(4);
    send_byte(8'h88); send_byte(8'h48); shift_n(24, 0, r);
    wclk(4); cs_n = 1; wclk(6);
    chk("R2 flagged byte dropped", r, mode_word);

    for (int i = 0; i < 4; i++) begin
      v = 24'h2468AC * i + 24'd1;
      strobe(v);
      chk("R5 R7 pin low after strobe", {23'd0, sdo_rdy}, 24'd0);
      txn(8'h40, 8, 0, r); chk("R5 status flag", r, 24'h00);
      chk("R6 status read keeps flag", {23'd0, sdo_rdy}, 24'd0);
      txn(8'h58, 24, 0, r); chk("R5 data", r, v);
      chk("R6 pin high after data read", {23'd0, sdo_rdy}, 24'd1);
    end
    old = v;

    txn(8'h18, 24, 24'hABCDEF, r);
    txn(8'h58, 24, 0, r); chk("R4 data write ignored", r, old);

    cs_n = 0; wclk(4);
    send_byte(8'h48); shift_n(10, 0, r);
    wclk(2); cs_n = 1; wclk(6);
    txn(8'h50, 24, 0, r); chk("R8 abort then command", r, cfg_word);

    cs_n = 0; wclk(4);
    send_byte(8'h58); shift_n(10, 0, r);
    strobe(24'h13579B);
    shift_n(14, 0, v);
    wclk(4); cs_n = 1; wclk(6);
    chk("R12 read keeps old word", {r[9:0], v[13:0]}, old);
    chk("R12 ready after deferred load", {23'd0, sdo_rdy}, 24'd0);
    txn(8'h58, 24, 0, r); chk("R12 deferred data", r, 24'h13579B);

    cs_n = 0; wclk(4);
    send_byte(8'h58); shift_n(23, 0, r);
    @(negedge clk); sclk = 0; sdi = 0;
    wclk(HALF); b = sdo_rdy; sclk = 1;
    @(negedge clk); @(negedge clk);
    conv_strobe = 1; conv_result = 24'hC0FFEE;
    @(negedge clk); conv_strobe = 0;
    wclk(HALF);
    wclk(4); cs_n = 1; wclk(6);
    chk("R12 edge read keeps old word", {r[22:0], b}, 24'h13579B);
    chk("R12 edge ready", {23'd0, sdo_rdy}, 24'd0);
    txn(8'h58, 24, 0, r); chk("R12 edge data", r, 24'hC0FFEE);

    txn(8'h5C, 0, 0, r);
    for (int i = 0; i < 3; i++) begin
      v = 24'h9E3779 * (i + 3);
      strobe(v);
      cs_n = 0; wclk(6);
      shift_n(24, 0, r);
      wclk(4);
      chk("R9 auto result", r, v);
      chk("R9 pin high after auto read", {23'd0, sdo_rdy}, 24'd1);
      cs_n = 1; wclk(6);
    end
    txn(8'h58, 0, 0, r);
    strobe(24'h0A0B0C);
    txn(8'h40, 8, 0, r); chk("R10 status after exit", r, 24'h00);
    txn(8'h58, 24, 0, r); chk("R10 data after exit", r, 24'h0A0B0C);

    txn(8'h08, 24, 24'h123456, r);
    cs_n = 0; wclk(4);
    for (int i = 0; i < 4; i++) send_byte(8'hFF);
    send_byte(8'hFE);
    wclk(4); cs_n = 1; wclk(6);
    txn(8'h48, 24, 0, r); chk("R11 39 ones no reset", r, 24'h123456);
    strobe(24'h777777);
    cs_n = 0; wclk(4);
    for (int i = 0; i < 5; i++) send_byte(8'hFF);
    wclk(4); cs_n = 1; wclk(6);
    chk("R11 pin high after reset", {23'd0, sdo_rdy}, 24'd1);
    txn(8'h48, 24, 0, r); chk("R11 mode reset", r, 24'h080060);
    txn(8'h70, 24, 0, r); chk("R11 offset reset", r, 24'h800000);
    txn(8'h58, 24, 0, r); chk("R11 data reset", r, 24'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule